// File: doc/BRIEF.md
# Three-Thread Interleaved Montgomery Multiplier

This block computes three independent Montgomery products, A·B·2^(−n) mod P, that share one modulus. Each operand is n = W·S bits wide and is consumed W bits at a time. The method scans the operand words and interleaves partial products with reduction. For each word of A, the loop folds the partial product into a running accumulator, derives a W-bit quotient digit from the low word, adds that multiple of P and drops the low W bits. After the last word of A, one conditional subtraction brings the accumulator below P.

Each word step depends on the accumulator of the step before it, and the datapath is a pipeline of three stages, each one cycle long. The block therefore rotates the three operations through the pipeline one word at a time: thread 0, thread 1, thread 2, then thread 0 again. Every stage is busy on every cycle of a run. The caller supplies the six operands, P and the constant −P⁻¹ mod 2^W, and pulses `start`. The block captures them and returns all three results together with a one-cycle `done` pulse.

Top module: `mont_tri_mult`

## Requirements
- R1: While `rst_n` is low on a clock edge, `busy` and `done` read 0 after that edge and all three results read 0.
- R2: With P odd, P < 2^n, A < P and B < P, and `mod_pinv` equal to −P⁻¹ mod 2^W, result k equals A_k·B_k·2^(−n) mod P for each thread k in 0..2.
- R3: Every result presented with `done` is strictly less than P. This covers accumulators that end between P and 2P.
- R4: `done` is high for exactly one cycle, 3·S+2 clock edges after the edge that accepted `start`.
- R5: `busy` is high from the accepting edge until the edge that raises `done`, and it falls on that same edge.
- R6: A `start` pulse while `busy` is high is ignored. The running results and the timing of `done` are those of the accepted request.
- R7: After `done`, the three results hold their values until a later accepted request produces new ones.
- R8: Operand, modulus and constant inputs are sampled only on the accepting edge. Changing them during a run has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a group of three products; accepted when `busy` is low |
| op_a0 | input | W·S | Multiplicand, thread 0 |
| op_a1 | input | W·S | Multiplicand, thread 1 |
| op_a2 | input | W·S | Multiplicand, thread 2 |
| op_b0 | input | W·S | Multiplier, thread 0 |
| op_b1 | input | W·S | Multiplier, thread 1 |
| op_b2 | input | W·S | Multiplier, thread 2 |
| mod_p | input | W·S | Shared odd modulus |
| mod_pinv | input | W | −P⁻¹ mod 2^W |
| busy | output | 1 | Group in progress |
| done | output | 1 | One-cycle pulse: all three results valid |
| res0 | output | W·S | Product, thread 0 |
| res1 | output | W·S | Product, thread 1 |
| res2 | output | W·S | Product, thread 2 |

## Verification
The bench targets a modulus of one (every product zero) and operands of P−1 squared. It also uses an all-ones modulus the full n bits wide, where a narrow accumulator would lose its top carry and return a wrong residue, and random odd moduli of many widths, some of which land the accumulator in [P, 2P). A missing final subtraction would show there as a result of P or more. It pulses `start` in the middle of a run and scrambles the inputs right after acceptance. A design that re-captured its inputs would return the wrong products or move `done`. A stage that read the accumulator one cycle early would mix threads and fail R2 on all three.

// File: rtl/mtm_pkg.sv
// Shared constants and helpers for the three-thread Montgomery multiplier.
// Assumes exactly three threads, which matches the three-stage pipeline depth.
package mtm_pkg;
    localparam int NTHREADS = 3;

    typedef logic [1:0] thr_t;

    // Round-robin successor of a thread index.
    function automatic thr_t next_thr(thr_t t);
        return (t == thr_t'(NTHREADS - 1)) ? thr_t'(0) : thr_t'(t + 2'd1);
    endfunction
endpackage

// File: rtl/mtm_ctrl.sv
// Issue sequencer: after an accepted start it emits one (thread, word) slot per
// cycle, threads rotating fastest, for S words. Assumes the pipeline drains by
// itself; busy covers both issue and the slots still in flight.
module mtm_ctrl
    import mtm_pkg::*;
#(
    parameter int S = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                pipe_busy,
    output logic                accept,
    output logic                busy,
    output logic                iss_v,
    output thr_t                iss_thr,
    output logic [WDW-1:0]      iss_word,
    output logic                iss_last
);
    localparam int WDW = (S > 1) ? $clog2(S) : 1;

    logic           run;
    thr_t           thr;
    logic [WDW-1:0] word;

    assign busy     = run | pipe_busy;
    assign accept   = start & ~busy;
    assign iss_v    = run;
    assign iss_thr  = thr;
    assign iss_word = word;
    assign iss_last = (word == WDW'(S - 1));

    // Step the slot counter: threads rotate every cycle, word advances per round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            thr  <= '0;
            word <= '0;
        end else if (accept) begin
            run  <= 1'b1;
            thr  <= '0;
            word <= '0;
        end else if (run) begin
            thr <= next_thr(thr);
            if (thr == thr_t'(NTHREADS - 1)) begin
                if (iss_last) begin
                    run  <= 1'b0;
                    word <= '0;
                end else begin
                    word <= word + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtm_mac.sv
// Stage 1: t = a_word * B + S_acc, registered. Assumes S_acc < 2P and B < 2^N,
// so the sum fits TW = N + W + 2 bits.
module mtm_mac
    import mtm_pkg::*;
#(
    parameter int W  = 34,
    parameter int N  = 136,
    parameter int TW = N + W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  thr_t          in_thr,
    input  logic          in_last,
    input  logic [W-1:0]  a_word,
    input  logic [N-1:0]  b,
    input  logic [N:0]    s_acc,
    output logic          o_v,
    output thr_t          o_thr,
    output logic          o_last,
    output logic [TW-1:0] o_t
);
    logic [TW-1:0] t_c;

    assign t_c = TW'(a_word) * TW'(b) + TW'(s_acc);

    // Register the partial product sum and its slot tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_v    <= 1'b0;
            o_thr  <= '0;
            o_last <= 1'b0;
            o_t    <= '0;
        end else begin
            o_v    <= in_v;
            o_thr  <= in_thr;
            o_last <= in_last;
            o_t    <= t_c;
        end
    end
endmodule

// File: rtl/mtm_quot.sv
// Stage 2: quotient digit q = (t mod 2^W) * (-P^-1) mod 2^W, registered along
// with t. Assumes pinv is the negated inverse of an odd P modulo 2^W.
module mtm_quot
    import mtm_pkg::*;
#(
    parameter int W  = 34,
    parameter int TW = 172
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  thr_t          in_thr,
    input  logic          in_last,
    input  logic [TW-1:0] in_t,
    input  logic [W-1:0]  pinv,
    output logic          o_v,
    output thr_t          o_thr,
    output logic          o_last,
    output logic [TW-1:0] o_t,
    output logic [W-1:0]  o_q
);
    logic [W-1:0] q_c;

    assign q_c = in_t[W-1:0] * pinv;

    // Register the digit next to the value it will clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_v    <= 1'b0;
            o_thr  <= '0;
            o_last <= 1'b0;
            o_t    <= '0;
            o_q    <= '0;
        end else begin
            o_v    <= in_v;
            o_thr  <= in_thr;
            o_last <= in_last;
            o_t    <= in_t;
            o_q    <= q_c;
        end
    end
endmodule

// File: rtl/mtm_red.sv
// Stage 3 (combinational; the accumulator bank is its register):
// s_new = (t + q*P) / 2^W and the conditionally reduced result s_new mod P.
// Assumes s_new < 2P, which holds when A, B < P.
module mtm_red #(
    parameter int W  = 34,
    parameter int N  = 136,
    parameter int TW = N + W + 2
) (
    input  logic [TW-1:0] in_t,
    input  logic [W-1:0]  in_q,
    input  logic [N-1:0]  p,
    output logic [N:0]    s_new,
    output logic [N-1:0]  res
);
    logic [TW-1:0] sum;
    logic [N:0]    diff;

    assign sum   = in_t + TW'(in_q) * TW'(p);
    assign s_new = sum[W +: N+1];
    assign diff  = s_new - {1'b0, p};
    assign res   = (s_new >= {1'b0, p}) ? diff[N-1:0] : s_new[N-1:0];
endmodule

// File: rtl/mont_tri_mult.sv
// Top: three Montgomery products A_k*B_k*2^-N mod P sharing P, interleaved word
// by word through a three-stage pipeline. Assumes P odd, A_k, B_k < P, and
// pinv = -P^-1 mod 2^W. Inputs are captured on the accepting edge only.
module mont_tri_mult
    import mtm_pkg::*;
#(
    parameter int W = 34,
    parameter int S = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W*S-1:0]   op_a0,
    input  logic [W*S-1:0]   op_a1,
    input  logic [W*S-1:0]   op_a2,
    input  logic [W*S-1:0]   op_b0,
    input  logic [W*S-1:0]   op_b1,
    input  logic [W*S-1:0]   op_b2,
    input  logic [W*S-1:0]   mod_p,
    input  logic [W-1:0]     mod_pinv,
    output logic             busy,
    output logic             done,
    output logic [W*S-1:0]   res0,
    output logic [W*S-1:0]   res1,
    output logic [W*S-1:0]   res2
);
    localparam int N   = W * S;
    localparam int TW  = N + W + 2;
    localparam int WDW = (S > 1) ? $clog2(S) : 1;

    logic [N-1:0] a_in  [NTHREADS];
    logic [N-1:0] b_in  [NTHREADS];
    logic [N-1:0] a_q   [NTHREADS];
    logic [N-1:0] b_q   [NTHREADS];
    logic [N:0]   s_acc [NTHREADS];
    logic [N-1:0] res_q [NTHREADS];
    logic [N-1:0] p_q;
    logic [W-1:0] pinv_q;

    logic           accept, pipe_busy, iss_v, iss_last;
    thr_t           iss_thr;
    logic [WDW-1:0] iss_word;

    logic [N-1:0]  a_sel, b_sel;
    logic [N:0]    s_sel;
    logic [W-1:0]  a_word;

    logic          s1_v, s1_last, s2_v, s2_last;
    thr_t          s1_thr, s2_thr;
    logic [TW-1:0] s1_t, s2_t;
    logic [W-1:0]  s2_q;
    logic [N:0]    s_new;
    logic [N-1:0]  red_res;
    logic          done_q;

    assign a_in[0] = op_a0;
    assign a_in[1] = op_a1;
    assign a_in[2] = op_a2;
    assign b_in[0] = op_b0;
    assign b_in[1] = op_b1;
    assign b_in[2] = op_b2;

    assign pipe_busy = s1_v | s2_v;
    assign done      = done_q;
    assign res0      = res_q[0];
    assign res1      = res_q[1];
    assign res2      = res_q[2];

    mtm_ctrl #(.S(S)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pipe_busy(pipe_busy),
        .accept   (accept),
        .busy     (busy),
        .iss_v    (iss_v),
        .iss_thr  (iss_thr),
        .iss_word (iss_word),
        .iss_last (iss_last)
    );

    // Capture operands, modulus and constant on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTHREADS; k++) begin
                a_q[k] <= '0;
                b_q[k] <= '0;
            end
            p_q    <= '0;
            pinv_q <= '0;
        end else if (accept) begin
            for (int k = 0; k < NTHREADS; k++) begin
                a_q[k] <= a_in[k];
                b_q[k] <= b_in[k];
            end
            p_q    <= mod_p;
            pinv_q <= mod_pinv;
        end
    end

    // Select the issuing thread's operands and accumulator.
    always_comb begin
        a_sel = '0;
        b_sel = '0;
        s_sel = '0;
        for (int k = 0; k < NTHREADS; k++) begin
            if (iss_thr == thr_t'(k)) begin
                a_sel = a_q[k];
                b_sel = b_q[k];
                s_sel = s_acc[k];
            end
        end
    end

    assign a_word = a_sel[iss_word * W +: W];

    mtm_mac #(.W(W), .N(N), .TW(TW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_v   (iss_v),
        .in_thr (iss_thr),
        .in_last(iss_last),
        .a_word (a_word),
        .b      (b_sel),
        .s_acc  (s_sel),
        .o_v    (s1_v),
        .o_thr  (s1_thr),
        .o_last (s1_last),
        .o_t    (s1_t)
    );

    mtm_quot #(.W(W), .TW(TW)) u_quot (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_v   (s1_v),
        .in_thr (s1_thr),
        .in_last(s1_last),
        .in_t   (s1_t),
        .pinv   (pinv_q),
        .o_v    (s2_v),
        .o_thr  (s2_thr),
        .o_last (s2_last),
        .o_t    (s2_t),
        .o_q    (s2_q)
    );

    mtm_red #(.W(W), .N(N), .TW(TW)) u_red (
        .in_t (s2_t),
        .in_q (s2_q),
        .p    (p_q),
        .s_new(s_new),
        .res  (red_res)
    );

    // Accumulator bank and result registers, written by stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTHREADS; k++) begin
                s_acc[k] <= '0;
                res_q[k] <= '0;
            end
        end else if (accept) begin
            for (int k = 0; k < NTHREADS; k++) s_acc[k] <= '0;
        end else if (s2_v) begin
            for (int k = 0; k < NTHREADS; k++) begin
                if (s2_thr == thr_t'(k)) begin
                    s_acc[k] <= s_new;
                    if (s2_last) res_q[k] <= red_res;
                end
            end
        end
    end

    // Completion pulse when the last thread's last word leaves stage 3.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= s2_v & s2_last & (s2_thr == thr_t'(NTHREADS - 1));
    end
endmodule

// File: rtl/mtm_checker.sv
// Protocol and range properties for mont_tri_mult, attached with bind.
module mtm_checker #(
    parameter int N = 136
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] r0,
    input logic [N-1:0] r1,
    input logic [N-1:0] r2,
    input logic [N-1:0] p_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R3
    below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r0 < p_q && r1 < p_q && r2 < p_q));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable({r0, r1, r2}));
endmodule

bind mont_tri_mult mtm_checker #(.N(N)) u_mtm_checker (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .r0   (res0),
    .r1   (res1),
    .r2   (res2),
    .p_q  (p_q)
);

// File: tb/test_mont_tri_mult.sv
// Bench: per-cycle model of busy/done plus a bit-serial reference product.
module test_mont_tri_mult;
    localparam int W   = 34;
    localparam int S   = 4;
    localparam int N   = W * S;
    localparam int LAT = 3 * S + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] a0 = '0, a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0, p = '0;
    logic [W-1:0] pinv = '0;
    logic         busy, done;
    logic [N-1:0] r0, r1, r2;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mont_tri_mult #(.W(W), .S(S)) i_mont_tri_mult (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a0(a0), .op_a1(a1), .op_a2(a2),
        .op_b0(b0), .op_b1(b1), .op_b2(b2),
        .mod_p(p), .mod_pinv(pinv),
        .busy(busy), .done(done), .res0(r0), .res1(r1), .res2(r2)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: (A*B mod P) halved n times modulo P.
    function automatic logic [N-1:0] mont_ref(logic [N-1:0] a, logic [N-1:0] b,
                                              logic [N-1:0] m);
        logic [2*N-1:0] aa, bb, mm, prod;
        logic [N+1:0]   x;
        aa = {{N{1'b0}}, a};
        bb = {{N{1'b0}}, b};
        mm = {{N{1'b0}}, m};
        prod = (aa * bb) % mm;
        x = prod[N+1:0];
        for (int k = 0; k < N; k++) begin
            if (x[0]) x = x + {2'b00, m};
            x = x >> 1;
        end
        return x[N-1:0];
    endfunction

    function automatic logic [W-1:0] neg_inv(logic [N-1:0] m);
        logic [W-1:0] lo, x;
        lo = m[W-1:0];
        x  = lo;
        for (int k = 0; k < 6; k++) x = x * (W'(2) - lo * x);
        return -x;
    endfunction

    function automatic logic [N-1:0] rand_wide(int bits);
        logic [N-1:0] v = '0;
        for (int k = 0; k < 5; k++) v = (v << 32) | N'($urandom);
        if (bits < N) v &= (N'(1) << bits) - N'(1);
        return v;
    endfunction

    function automatic logic [N-1:0] rand_mod();
        int bits = 2 + int'($urandom % 127);
        logic [N-1:0] v = rand_wide(bits);
        v[0] = 1'b1;
        v[bits-1] = 1'b1;
        return v;
    endfunction

    // One group: drive, then compare busy/done on every cycle and the results.
    task automatic run_group(input logic [N-1:0] xa0, xa1, xa2, xb0, xb1, xb2, xp,
                             input bit inject);
        logic [N-1:0] e0, e1, e2, h0, h1, h2;
        e0 = mont_ref(xa0, xb0, xp);
        e1 = mont_ref(xa1, xb1, xp);
        e2 = mont_ref(xa2, xb2, xp);
        @(negedge clk);
        a0 = xa0; a1 = xa1; a2 = xa2; b0 = xb0; b1 = xb1; b2 = xb2;
        p = xp; pinv = neg_inv(xp); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R8: scramble every input right after acceptance
        p = rand_mod(); pinv = neg_inv(p);
        a0 = rand_wide(N); a1 = rand_wide(N); a2 = rand_wide(N);
        b0 = rand_wide(N); b1 = rand_wide(N); b2 = rand_wide(N);
        for (int k = 0; k <= LAT + 4; k++) begin
            if (k <= LAT) begin
                chk(busy == (k < LAT), "R5", $sformatf("busy at cycle %0d", k),
                    N'(busy), N'(k < LAT));
                chk(done == (k == LAT), "R4", $sformatf("done at cycle %0d", k),
                    N'(done), N'(k == LAT));
            end
            if (k == LAT) begin
                chk(r0 == e0, "R2", "thread 0 product", r0, e0);
                chk(r1 == e1, "R2", "thread 1 product", r1, e1);
                chk(r2 == e2, "R2", "thread 2 product", r2, e2);
                chk(r0 < xp && r1 < xp && r2 < xp, "R3", "results below P",
                    (r0 > r1) ? r0 : r1, xp);
                h0 = r0; h1 = r1; h2 = r2;
            end
            if (k > LAT) begin
                chk(!done, "R4", "done single cycle", N'(done), '0);
                chk(r0 == h0 && r1 == h1 && r2 == h2, "R7", "results held",
                    r0 ^ h0 ^ r1 ^ h1 ^ r2 ^ h2, '0);
            end
            // R6: a start pulse in mid-run must be ignored
            if (inject && k == 5) start = 1'b1;
            if (k == 6) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] m, big;
        repeat (3) @(negedge clk);
        // R1: outputs at reset
        chk(!busy, "R1", "busy in reset", N'(busy), '0);
        chk(!done, "R1", "done in reset", N'(done), '0);
        chk(r0 == '0 && r1 == '0 && r2 == '0, "R1", "results in reset", r0 | r1 | r2, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: small modulus, distinct threads
        run_group(N'(3), N'(7), N'(12), N'(5), N'(11), N'(2), N'(13), 1'b0);
        // R2: modulus of one gives zero everywhere
        run_group('0, '0, '0, '0, '0, '0, N'(1), 1'b0);
        // R2/R3: P-1 squared, 128-bit all-ones modulus
        m = {{(N-128){1'b0}}, {128{1'b1}}};
        run_group(m - 1, N'(1), '0, m - 1, N'(1), m - 2, m, 1'b0);
        // R2/R3: full-width all-ones modulus stresses the accumulator top bits
        big = {N{1'b1}};
        run_group(big - 1, big - 2, N'(1), big - 1, big - 1, big - 1, big, 1'b1);
        // R2/R3/R6/R8: random odd moduli of many widths
        for (int g = 0; g < 24; g++) begin
            m = rand_mod();
            run_group(rand_wide(N) % m, rand_wide(N) % m, rand_wide(N) % m,
                      rand_wide(N) % m, rand_wide(N) % m, rand_wide(N) % m,
                      m, (g % 3) == 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule